// File: doc/BRIEF.md
# Three-Channel Programmable Pulse Divider

This block takes a master pulse train, samples it in a faster system clock domain and drives three divided pulse outputs. Each channel has its own division code and emits one output pulse for every N master pulses, where N runs from 1 to 8. An output pulse is not a square wave. It is the master pulse itself, gated by the channel's "count is zero" state, so it lasts exactly as long as the master high phase it copies, two system clocks later. The block suits beat or step sequencers that run at fixed fractions of one master rate.

Each channel is a two-state machine. `CH_ZERO` means the phase count is zero and the output follows the master level. `CH_SKIP` means the count is non-zero and the output is held low. All three channels share one synchronizer, which detects the falling edge of the master pulse. The transitions happen only on that falling edge:

- **ZERO→ZERO (wrap):** taken when the active code is 0.
- **ZERO→SKIP (start):** taken otherwise, and the count becomes 1.
- **SKIP→SKIP (step):** taken while the count is below the active code, and the count goes up by one.
- **SKIP→ZERO (wrap):** taken when the count equals the active code.

On every wrap, and during reset, the channel loads its division code from its port. A synchronous reset sends every channel to `CH_ZERO`, which aligns all three channels in phase.

Top module: `clkdiv3`

## Requirements
- R1: Channel c takes its code from `ratio_i[3c+2:3c]`, and code n means divide by n+1: the channel emits a pulse on master pulse k (counted from 0 after reset) when k mod (n+1) is 0.
- R2: Code 0 on a channel passes every master pulse through to that channel's output.
- R3: An output is high only while the master level, delayed by two system clocks, is high. An emitted pulse has the same width in system clocks as the master high phase that produced it.
- R4: An output pulse starts exactly two system clocks after its master pulse rises.
- R5: Outputs are low in the first cycle after reset is released. The first master pulse after reset is emitted on all three channels.
- R6: A reset applied mid-run realigns all channels, so that their phases then match those of a fresh start.
- R7: A code change takes effect at the channel's next wrap. The cycle already in progress finishes with the old code.
- R8: Reset has priority over counting: master pulses that occur while reset is high are not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| mpulse_i | input | 1 | Master pulse train, asynchronous to clk_i |
| ratio_i | input | 9 | Three 3-bit division codes, channel 0 in the low bits |
| div_o | output | 3 | Divided pulse outputs, one bit per channel |

## Verification
The bench goes after these corner cases:

- **Divide-by-1 against divide-by-8:** a divide-by-1 channel wraps on every falling edge. A design that handled that state like the others would drop pulses or divide by 2.
- **Code change mid-cycle:** a design that applied the new code at once would emit a pulse at the wrong master pulse.
- **Single-cycle master pulses:** a design that latched the output or gated it on the wrong flop would stretch or clip the width.
- **Reset mid-run, with a master pulse inside the reset window:** a design whose counting beat its reset would come out of reset misaligned or skip the first common pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int unsigned NUM_CH_DEF  = 3;
    localparam int unsigned RATIO_W_DEF = 3;

    typedef enum logic {
        CH_ZERO = 1'b0,
        CH_SKIP = 1'b1
    } ch_state_e;
endpackage

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic lvl_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              lvl_d_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            chain_q <= '0;
            lvl_d_q <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            lvl_d_q <= chain_q[STAGES-1];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign fall_o = lvl_d_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int unsigned RATIO_W = RATIO_W_DEF
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               lvl_i,
    input  logic               fall_i,
    input  logic [RATIO_W-1:0] code_i,
    output logic               div_o
);
    ch_state_e          state_q, state_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] act_q, act_d;

    // state register
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= CH_ZERO;
            cnt_q   <= '0;
            act_q   <= code_i;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            act_q   <= act_d;
        end
    end

    // transitions, evaluated only on a detected master falling edge
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        act_d   = act_q;
        if (fall_i) begin
            unique case (state_q)
                CH_ZERO: begin
                    if (act_q == '0) begin
                        act_d = code_i;
                    end else begin
                        state_d = CH_SKIP;
                        cnt_d   = RATIO_W'(1);
                    end
                end
                CH_SKIP: begin
                    if (cnt_q == act_q) begin
                        state_d = CH_ZERO;
                        cnt_d   = '0;
                        act_d   = code_i;
                    end else begin
                        cnt_d = cnt_q + RATIO_W'(1);
                    end
                end
                default: state_d = CH_ZERO;
            endcase
        end
    end

    // output: master level gated by the zero state
    always_comb begin
        unique case (state_q)
            CH_ZERO: div_o = lvl_i;
            CH_SKIP: div_o = 1'b0;
            default: div_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/clkdiv3.sv
module clkdiv3
    import clkdiv_pkg::*;
#(
    parameter int unsigned NUM_CH  = NUM_CH_DEF,
    parameter int unsigned RATIO_W = RATIO_W_DEF
) (
    input  logic                      clk_i,
    input  logic                      rst_i,
    input  logic                      mpulse_i,
    input  logic [NUM_CH*RATIO_W-1:0] ratio_i,
    output logic [NUM_CH-1:0]         div_o
);
    logic lvl;
    logic fall;

    clkdiv_sync #(.STAGES(2)) sync_i (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (mpulse_i),
        .lvl_o   (lvl),
        .fall_o  (fall)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        clkdiv_chan #(.RATIO_W(RATIO_W)) chan_i (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .lvl_i  (lvl),
            .fall_i (fall),
            .code_i (ratio_i[c*RATIO_W +: RATIO_W]),
            .div_o  (div_o[c])
        );
    end
endmodule

// File: rtl/clkdiv3_chk.sv
module clkdiv3_chk #(
    parameter int unsigned NUM_CH = 3
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              mpulse_i,
    input logic [NUM_CH-1:0] div_o
);
    logic s1_q, s2_q, s2_d_q, first_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
            s2_d_q  <= 1'b0;
            first_q <= 1'b1;
        end else begin
            s1_q   <= mpulse_i;
            s2_q   <= s1_q;
            s2_d_q <= s2_q;
            if (s2_d_q && !s2_q) first_q <= 1'b0;
        end
    end

    p_out_gated_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (|div_o) |-> s2_q)
        else $error("output high outside delayed master pulse");

    p_reset_clears_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (div_o == '0))
        else $error("output high right after reset");

    p_first_all_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        (first_q && s2_q) |-> (&div_o))
        else $error("first pulse after reset missing on a channel");

    for (genvar c = 0; c < NUM_CH; c++) begin : g_rise
        p_rise_aligned_r4: assert property (@(posedge clk_i) disable iff (rst_i)
            $rose(div_o[c]) |-> $rose(s2_q))
            else $error("output rose away from a master rise");
    end
endmodule

bind clkdiv3 clkdiv3_chk #(.NUM_CH(NUM_CH)) chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .mpulse_i (mpulse_i),
    .div_o    (div_o)
);

// File: tb/clkdiv3_tb_top.sv
module clkdiv3_tb_top;
    localparam int NCH = 3;

    typedef struct {
        int    start;
        int    width;
        string tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           mpulse = 1'b0;
    logic [3*NCH-1:0] ratio = '0;
    logic [NCH-1:0] div;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    exp_t q0[$];
    exp_t q1[$];
    exp_t q2[$];
    int   kk[NCH];
    int   ac[NCH];
    bit   first_after_rst = 1'b1;
    string phase_tag = "R1";

    clkdiv3 dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .mpulse_i (mpulse),
        .ratio_i  (ratio),
        .div_o    (div)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int code_of(int c);
        return int'(ratio[c*3 +: 3]);
    endfunction

    task automatic push(int c, exp_t e);
        case (c)
            0: q0.push_back(e);
            1: q1.push_back(e);
            default: q2.push_back(e);
        endcase
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // driver: one master pulse, high h cycles, low l cycles; model updated
    task automatic send_pulse(int h, int l);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            if (kk[c] == 0) begin
                exp_t e;
                e.start = cyc + 2;
                e.width = h;
                e.tag   = first_after_rst ? "R5" : (ac[c] == 0 ? "R2" : phase_tag);
                push(c, e);
            end
        end
        mpulse = 1'b1;
        repeat (h) @(negedge clk);
        mpulse = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            if (kk[c] == ac[c]) begin
                kk[c] = 0;
                ac[c] = code_of(c);
            end else begin
                kk[c]++;
            end
        end
        first_after_rst = 1'b0;
        repeat (l - 1) @(negedge clk);
    endtask

    task automatic do_reset(bit pulse_inside);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        if (pulse_inside) begin
            mpulse = 1'b1;
            repeat (2) @(negedge clk);
            mpulse = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < NCH; c++) begin
            kk[c] = 0;
            ac[c] = code_of(c);
        end
        first_after_rst = 1'b1;
        @(negedge clk);
        check(div == '0, "R5", "outputs after reset", int'(div), 0);
    endtask

    // monitor: measures every output pulse and compares with the scoreboard
    int  st[NCH];
    bit  prev[NCH];
    exp_t cur[NCH];
    always @(negedge clk) begin
        for (int c = 0; c < NCH; c++) begin
            if (!rst && div[c] && !prev[c]) begin
                int qs;
                exp_t e;
                qs = (c == 0) ? q0.size() : (c == 1) ? q1.size() : q2.size();
                st[c] = cyc;
                if (qs == 0) begin
                    check(1'b0, "R1", $sformatf("ch%0d unexpected pulse at", c), cyc, -1);
                    cur[c].start = cyc;
                    cur[c].width = -1;
                    cur[c].tag   = "R1";
                end else begin
                    case (c)
                        0: e = q0.pop_front();
                        1: e = q1.pop_front();
                        default: e = q2.pop_front();
                    endcase
                    cur[c] = e;
                    check(cyc == e.start, {e.tag, " R4"},
                          $sformatf("ch%0d pulse start", c), cyc, e.start);
                end
            end
            if (!rst && !div[c] && prev[c] && cur[c].width >= 0) begin
                check(cyc - st[c] == cur[c].width, {cur[c].tag, " R3"},
                      $sformatf("ch%0d pulse width", c), cyc - st[c], cur[c].width);
            end
            prev[c] = rst ? 1'b0 : div[c];
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            kk[c] = 0; ac[c] = 0; st[c] = 0; prev[c] = 0;
            cur[c].start = 0; cur[c].width = -1; cur[c].tag = "R1";
        end
        // ratios: ch0 /1, ch1 /3, ch2 /8
        ratio = {3'd7, 3'd2, 3'd0};
        repeat (3) @(negedge clk);
        check(div == '0, "R5", "outputs during reset", int'(div), 0);
        do_reset(1'b0);
        phase_tag = "R1";
        for (int i = 0; i < 24; i++) send_pulse(3, 4);
        // code change mid-cycle, varied widths
        phase_tag = "R7";
        ratio = {3'd5, 3'd3, 3'd1};
        for (int i = 0; i < 20; i++) send_pulse((i % 3 == 0) ? 1 : (i % 3 == 1) ? 2 : 5, 4 + (i % 2));
        phase_tag = "R7";
        ratio = {3'd0, 3'd6, 3'd4};
        for (int i = 0; i < 9; i++) send_pulse(2, 5);
        // reset mid-run realigns; pulse inside reset ignored
        ratio = {3'd1, 3'd4, 3'd6};
        do_reset(1'b1);
        phase_tag = "R6";
        for (int i = 0; i < 16; i++) send_pulse(1 + (i % 4), 4);
        phase_tag = "R8";
        do_reset(1'b1);
        for (int i = 0; i < 10; i++) send_pulse(2, 4);
        repeat (10) @(negedge clk);
        check(q0.size() == 0, "R1", "ch0 missing pulses", q0.size(), 0);
        check(q1.size() == 0, "R1", "ch1 missing pulses", q1.size(), 0);
        check(q2.size() == 0, "R1", "ch2 missing pulses", q2.size(), 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog expired actual 0 expected 1");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule